// File: doc/BRIEF.md
# Multi-Level Trace Sequencer

This block is the trace control engine of a logic analyzer. It walks a program of up to sixteen levels. At each level the incoming sample is compared against four search patterns, and each pattern carries a value and a don't-care mask. A matching pattern fires the command bound to it:

- begin tracing, after a programmable number of further samples;
- stop;
- jump to a named level;
- advance to the next level.

While tracing is active, each valid sample is sent to the trace memory with a record strobe. The strobe is tagged with the level that was current when the sample arrived.

Software loads the pattern slots one at a time through a write port, sets the delay count and pulses start. Sequencing begins at level 0. It ends in three ways: a stop command, an advance out of the last level, or the trace memory filling up. The done flag then stays high until the next start.

Top module: `trace_seq`

## Requirements
- R1: After reset, trace_active, rec_en and done are 0 and cur_level is 0; no sample has any effect until start.
- R2: A start pulse clears done and trace_active and sets cur_level to 0. Samples are then evaluated from the following cycle.
- R3: A valid sample matches a pattern slot of the current level when the slot is enabled and the sample equals the slot value on every bit whose mask bit is 1. Among the matching slots, the lowest slot index wins. With no match, the level and the trace state are unchanged. Command codes are TRACE=0, STOP=1, JUMP=2 and ADVANCE=3.
- R4: A TRACE match while tracing is neither active nor pending loads delay_cnt = D. The qualifying sample and the next D valid samples are not recorded, and trace_active rises in the cycle after the last of them (after the qualifying sample when D=0). Further TRACE matches while tracing is active or pending have no effect.
- R5: Each valid sample taken while trace_active is high gives rec_en high in the following cycle. In that cycle rec_level holds the level at which the sample arrived.
- R6: A JUMP match sets cur_level to the slot's target level.
- R7: An ADVANCE match raises cur_level by one. From the last level (15) it instead ends the run: done rises and trace_active falls. The advancing sample is still recorded if tracing was active.
- R8: A STOP match ends the run at once. done rises, trace_active falls, and the stopping sample is not recorded.
- R9: At most 515 samples are recorded per run. The 515th record ends the run with done high, and later samples are not recorded.
- R10: A cycle with smp_valid low changes neither the level, the delay progress nor the trace state, and records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one pattern slot |
| cfg_level | input | 4 | Level of the slot written |
| cfg_slot | input | 2 | Slot index within the level |
| cfg_en | input | 1 | Slot enable |
| cfg_value | input | 16 | Compare value |
| cfg_mask | input | 16 | Compare mask, 1 = bit compared |
| cfg_cmd | input | 2 | Command bound to the slot |
| cfg_target | input | 4 | Jump target level |
| delay_cnt | input | 16 | Samples between qualification and tracing |
| start | input | 1 | Begin a run at level 0 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Sample word |
| trace_active | output | 1 | High while tracing |
| rec_en | output | 1 | Write strobe to the trace memory |
| rec_level | output | 4 | Level tag for the recorded word |
| cur_level | output | 4 | Current sequencer level |
| done | output | 1 | Run finished |

## Verification
Recording and ending a run can fall on the same sample. One case is an ADVANCE out of level 15 while tracing, where the sample must be stored with tag 15 and done must rise in the same cycle. The other is a STOP while tracing, where done must rise and the strobe must stay low. Both are provoked by programmed sequences, and rec_en, rec_level and done are judged together in the cycle after the sample. A further coincidence is one sample matching two slots at once, where only the lower slot's command may act.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
    typedef enum logic [1:0] {
        CMD_TRACE = 2'd0,
        CMD_STOP  = 2'd1,
        CMD_JUMP  = 2'd2,
        CMD_ADV   = 2'd3
    } seq_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/tseq_pattern_bank.sv
module tseq_pattern_bank #(
    parameter int NUM_LEVELS = 16,
    parameter int NUM_PAT    = 4,
    parameter int SAMPLE_W   = 16,
    localparam int LW = $clog2(NUM_LEVELS),
    localparam int PW = $clog2(NUM_PAT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [LW-1:0]                 wr_level,
    input  logic [PW-1:0]                 wr_slot,
    input  logic                          wr_valid_bit,
    input  logic [SAMPLE_W-1:0]           wr_value,
    input  logic [SAMPLE_W-1:0]           wr_mask,
    input  logic [1:0]                    wr_cmd,
    input  logic [LW-1:0]                 wr_target,
    input  logic [LW-1:0]                 rd_level,
    input  logic [SAMPLE_W-1:0]           sample,
    output logic [NUM_PAT-1:0]            hit,
    output logic [NUM_PAT-1:0][1:0]       slot_cmd,
    output logic [NUM_PAT-1:0][LW-1:0]    slot_target
);
    logic                en_q   [NUM_LEVELS][NUM_PAT];
    logic [SAMPLE_W-1:0] val_q  [NUM_LEVELS][NUM_PAT];
    logic [SAMPLE_W-1:0] mask_q [NUM_LEVELS][NUM_PAT];
    logic [1:0]          cmd_q  [NUM_LEVELS][NUM_PAT];
    logic [LW-1:0]       tgt_q  [NUM_LEVELS][NUM_PAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LEVELS; l++) begin
                for (int p = 0; p < NUM_PAT; p++) begin
                    en_q[l][p]   <= 1'b0;
                    val_q[l][p]  <= '0;
                    mask_q[l][p] <= '0;
                    cmd_q[l][p]  <= '0;
                    tgt_q[l][p]  <= '0;
                end
            end
        end else if (wr_en) begin
            en_q[wr_level][wr_slot]   <= wr_valid_bit;
            val_q[wr_level][wr_slot]  <= wr_value;
            mask_q[wr_level][wr_slot] <= wr_mask;
            cmd_q[wr_level][wr_slot]  <= wr_cmd;
            tgt_q[wr_level][wr_slot]  <= wr_target;
        end
    end

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmp
        assign hit[p] = en_q[rd_level][p] &&
                        (((sample ^ val_q[rd_level][p]) & mask_q[rd_level][p]) == '0);
        assign slot_cmd[p]    = cmd_q[rd_level][p];
        assign slot_target[p] = tgt_q[rd_level][p];
    end
endmodule

// File: rtl/tseq_first_hit.sv
module tseq_first_hit #(
    parameter int NUM_PAT = 4,
    parameter int LW      = 4
) (
    input  logic [NUM_PAT-1:0]         hit,
    input  logic [NUM_PAT-1:0][1:0]    slot_cmd,
    input  logic [NUM_PAT-1:0][LW-1:0] slot_target,
    output logic                       any_hit,
    output logic [1:0]                 win_cmd,
    output logic [LW-1:0]              win_target
);
    always_comb begin
        any_hit    = 1'b0;
        win_cmd    = '0;
        win_target = '0;
        for (int p = NUM_PAT - 1; p >= 0; p--) begin
            if (hit[p]) begin
                any_hit    = 1'b1;
                win_cmd    = slot_cmd[p];
                win_target = slot_target[p];
            end
        end
    end
endmodule

// File: rtl/trace_seq.sv
module trace_seq
    import trace_seq_pkg::*;
#(
    parameter int NUM_LEVELS = 16,
    parameter int NUM_PAT    = 4,
    parameter int SAMPLE_W   = 16,
    parameter int DELAY_W    = 16,
    parameter int MEM_DEPTH  = 515,
    localparam int LW = $clog2(NUM_LEVELS),
    localparam int PW = $clog2(NUM_PAT),
    localparam int CW = $clog2(MEM_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [LW-1:0]       cfg_level,
    input  logic [PW-1:0]       cfg_slot,
    input  logic                cfg_en,
    input  logic [SAMPLE_W-1:0] cfg_value,
    input  logic [SAMPLE_W-1:0] cfg_mask,
    input  logic [1:0]          cfg_cmd,
    input  logic [LW-1:0]       cfg_target,
    input  logic [DELAY_W-1:0]  delay_cnt,
    input  logic                start,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                trace_active,
    output logic                rec_en,
    output logic [LW-1:0]       rec_level,
    output logic [LW-1:0]       cur_level,
    output logic                done
);
    localparam logic [LW-1:0] LAST_LEVEL = LW'(NUM_LEVELS - 1);
    localparam logic [CW-1:0] FULL_COUNT = CW'(MEM_DEPTH);

    typedef struct packed {
        seq_state_e        state;
        logic [LW-1:0]     level;
        logic              tracing;
        logic              pending;
        logic [DELAY_W-1:0] dleft;
        logic [CW-1:0]     nrec;
        logic              rec;
        logic [LW-1:0]     rec_lvl;
        logic              fin;
    } seq_t;

    seq_t s_d, s_q;

    logic [NUM_PAT-1:0]         hit;
    logic [NUM_PAT-1:0][1:0]    slot_cmd;
    logic [NUM_PAT-1:0][LW-1:0] slot_target;
    logic                       any_hit;
    logic [1:0]                 win_cmd;
    logic [LW-1:0]              win_target;

    tseq_pattern_bank #(
        .NUM_LEVELS(NUM_LEVELS), .NUM_PAT(NUM_PAT), .SAMPLE_W(SAMPLE_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_level(cfg_level), .wr_slot(cfg_slot),
        .wr_valid_bit(cfg_en), .wr_value(cfg_value), .wr_mask(cfg_mask),
        .wr_cmd(cfg_cmd), .wr_target(cfg_target),
        .rd_level(s_q.level), .sample(smp_data),
        .hit(hit), .slot_cmd(slot_cmd), .slot_target(slot_target)
    );

    tseq_first_hit #(.NUM_PAT(NUM_PAT), .LW(LW)) u_pick (
        .hit(hit), .slot_cmd(slot_cmd), .slot_target(slot_target),
        .any_hit(any_hit), .win_cmd(win_cmd), .win_target(win_target)
    );

    always_comb begin
        logic store;
        logic halt;
        s_d     = s_q;
        s_d.rec = 1'b0;
        store   = 1'b0;
        halt    = 1'b0;
        if (start) begin
            s_d.state   = ST_RUN;
            s_d.level   = '0;
            s_d.tracing = 1'b0;
            s_d.pending = 1'b0;
            s_d.dleft   = '0;
            s_d.nrec    = '0;
            s_d.fin     = 1'b0;
        end else if (s_q.state == ST_RUN && smp_valid) begin
            store = s_q.tracing;
            if (s_q.pending) begin
                if (s_q.dleft == DELAY_W'(1)) begin
                    s_d.pending = 1'b0;
                    s_d.tracing = 1'b1;
                end
                s_d.dleft = s_q.dleft - DELAY_W'(1);
            end
            if (any_hit) begin
                case (seq_cmd_e'(win_cmd))
                    CMD_TRACE: begin
                        if (!s_q.tracing && !s_q.pending) begin
                            if (delay_cnt == '0) begin
                                s_d.tracing = 1'b1;
                            end else begin
                                s_d.pending = 1'b1;
                                s_d.dleft   = delay_cnt;
                            end
                        end
                    end
                    CMD_STOP: begin
                        store = 1'b0;
                        halt  = 1'b1;
                    end
                    CMD_JUMP: s_d.level = win_target;
                    CMD_ADV: begin
                        if (s_q.level == LAST_LEVEL) halt = 1'b1;
                        else s_d.level = s_q.level + LW'(1);
                    end
                    default: ;
                endcase
            end
            if (store) begin
                s_d.rec     = 1'b1;
                s_d.rec_lvl = s_q.level;
                s_d.nrec    = s_q.nrec + CW'(1);
                if (s_q.nrec + CW'(1) == FULL_COUNT) halt = 1'b1;
            end
            if (halt) begin
                s_d.state   = ST_DONE;
                s_d.fin     = 1'b1;
                s_d.tracing = 1'b0;
                s_d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, level: '0, tracing: 1'b0, pending: 1'b0,
                     dleft: '0, nrec: '0, rec: 1'b0, rec_lvl: '0, fin: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign trace_active = s_q.tracing;
    assign rec_en       = s_q.rec;
    assign rec_level    = s_q.rec_lvl;
    assign cur_level    = s_q.level;
    assign done         = s_q.fin;
endmodule

// File: rtl/trace_seq_checker.sv
module trace_seq_checker #(
    parameter int LW        = 4,
    parameter int MEM_DEPTH = 515
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          smp_valid,
    input logic          trace_active,
    input logic          rec_en,
    input logic [LW-1:0] rec_level,
    input logic [LW-1:0] cur_level,
    input logic          done
);
    logic [15:0] rec_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rec_seen <= '0;
        else if (start)  rec_seen <= '0;
        else if (rec_en) rec_seen <= rec_seen + 16'd1;
    end

    a_r8_done_no_trace: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !trace_active);

    a_r5_rec_needs_trace: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |-> ($past(trace_active) && $past(smp_valid)));

    a_r5_rec_level_tag: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |-> (rec_level == $past(cur_level)));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !trace_active && cur_level == '0));

    a_r10_idle_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !smp_valid) |=> ($stable(cur_level) && $stable(trace_active) && !rec_en));

    a_r9_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
        rec_seen <= 16'(MEM_DEPTH));
endmodule

bind trace_seq trace_seq_checker #(.LW(LW), .MEM_DEPTH(MEM_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .trace_active(trace_active), .rec_en(rec_en), .rec_level(rec_level),
    .cur_level(cur_level), .done(done)
);

// File: tb/trace_seq_test.sv
module trace_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_level = '0;
    logic [1:0]  cfg_slot = '0;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_value = '0;
    logic [15:0] cfg_mask = '0;
    logic [1:0]  cfg_cmd = '0;
    logic [3:0]  cfg_target = '0;
    logic [15:0] delay_cnt = '0;
    logic        start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        trace_active, rec_en, done;
    logic [3:0]  rec_level, cur_level;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trace_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_level(cfg_level),
        .cfg_slot(cfg_slot), .cfg_en(cfg_en), .cfg_value(cfg_value),
        .cfg_mask(cfg_mask), .cfg_cmd(cfg_cmd), .cfg_target(cfg_target),
        .delay_cnt(delay_cnt), .start(start), .smp_valid(smp_valid),
        .smp_data(smp_data), .trace_active(trace_active), .rec_en(rec_en),
        .rec_level(rec_level), .cur_level(cur_level), .done(done)
    );

    // row: valid, data, exp rec_en, exp trace, exp level, exp rec_level, exp done
    localparam logic [27:0] TBL [11] = '{
        {1'b1, 16'h0005, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
        {1'b1, 16'h0011, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
        {1'b0, 16'h0011, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
        {1'b1, 16'h0001, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
        {1'b1, 16'h0002, 1'b0, 1'b1, 4'd0,  4'd0,  1'b0},
        {1'b1, 16'h0003, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
        {1'b1, 16'h0022, 1'b1, 1'b1, 4'd1,  4'd0,  1'b0},
        {1'b1, 16'h00C5, 1'b1, 1'b1, 4'd15, 4'd1,  1'b0},
        {1'b1, 16'h0007, 1'b1, 1'b1, 4'd15, 4'd15, 1'b0},
        {1'b1, 16'h00FF, 1'b1, 1'b0, 4'd15, 4'd15, 1'b1},
        {1'b1, 16'h0011, 1'b0, 1'b0, 4'd15, 4'd15, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_slot(input int lvl, input int slot, input bit en,
                              input logic [15:0] val, input logic [15:0] msk,
                              input logic [1:0] cmd, input int tgt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_level = 4'(lvl); cfg_slot = 2'(slot); cfg_en = en;
        cfg_value = val; cfg_mask = msk; cfg_cmd = cmd; cfg_target = 4'(tgt);
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int l = 0; l < 16; l++)
            for (int p = 0; p < 4; p++)
                write_slot(l, p, 1'b0, 16'h0, 16'h0, 2'd0, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1; smp_valid = 1'b0;
        @(posedge clk);
        #2;
        check(!done && !trace_active && cur_level == 4'd0, "R2 start", {done, trace_active, cur_level}, 0);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step(input bit v, input logic [15:0] d);
        @(negedge clk);
        smp_valid = v; smp_data = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nrec;
        repeat (3) @(posedge clk);
        #2;
        check(!trace_active && !rec_en && !done && cur_level == 0, "R1 reset state",
              {trace_active, rec_en, done, cur_level}, 0);
        @(negedge clk) rst_n = 1'b1;
        step(1'b1, 16'h0000);
        check(!rec_en && !trace_active && !done && cur_level == 0, "R1 no effect before start",
              {rec_en, trace_active, done, cur_level}, 0);

        // program for the table: R3 priority, R4 delay 2, R6 jump, R7 advance from 15
        write_slot(0, 0, 1'b1, 16'h0011, 16'hFFFF, 2'd0, 0);
        write_slot(0, 1, 1'b1, 16'h0022, 16'hFFFF, 2'd3, 0);
        write_slot(0, 2, 1'b1, 16'h0020, 16'h00F0, 2'd2, 7);
        write_slot(1, 0, 1'b1, 16'h00C0, 16'h00F0, 2'd2, 15);
        write_slot(15, 3, 1'b1, 16'h00FF, 16'hFFFF, 2'd3, 0);
        delay_cnt = 16'd2;
        pulse_start();
        for (int i = 0; i < 11; i++) begin
            logic [27:0] r;
            r = TBL[i];
            step(r[27], r[26:11]);
            check(rec_en == r[10], "R5/R8 rec_en (table)", rec_en, r[10]);
            check(trace_active == r[9], "R4/R7 trace_active (table)", trace_active, r[9]);
            check(cur_level == r[8:5], "R3/R6/R7 cur_level (table)", cur_level, r[8:5]);
            if (r[10]) check(rec_level == r[4:1], "R5 rec_level (table)", rec_level, r[4:1]);
            check(done == r[0], "R7 done (table)", done, r[0]);
        end

        // R3: disabled slot ignored, masked match taken
        clear_all();
        write_slot(0, 0, 1'b0, 16'h0033, 16'hFFFF, 2'd1, 0);
        write_slot(0, 1, 1'b1, 16'h0030, 16'h00F0, 2'd2, 3);
        pulse_start();
        step(1'b1, 16'h0033);
        check(cur_level == 4'd3 && !done, "R3 disabled slot skipped", cur_level, 3);

        // R4 delay 0, R8 stop not recorded, R10 invalid cycle
        clear_all();
        write_slot(0, 0, 1'b1, 16'h0F0F, 16'hFFFF, 2'd0, 0);
        write_slot(0, 1, 1'b1, 16'h0099, 16'hFFFF, 2'd1, 0);
        delay_cnt = 16'd0;
        pulse_start();
        step(1'b1, 16'h0F0F);
        check(trace_active && !rec_en, "R4 delay zero", {trace_active, rec_en}, 2);
        step(1'b0, 16'h0099);
        check(!rec_en && !done && trace_active, "R10 invalid ignored", {rec_en, done, trace_active}, 1);
        step(1'b1, 16'h0001);
        check(rec_en && rec_level == 0, "R5 record at level 0", {rec_en, rec_level}, 16);
        step(1'b1, 16'h0099);
        check(!rec_en && done && !trace_active, "R8 stop", {rec_en, done, trace_active}, 2);

        // R9 memory full
        delay_cnt = 16'd0;
        pulse_start();
        check(!done, "R2 done cleared", done, 0);
        step(1'b1, 16'h0F0F);
        nrec = 0;
        for (int k = 0; k < 520; k++) begin
            step(1'b1, 16'h5555);
            if (rec_en) nrec++;
        end
        check(nrec == 515, "R9 record count", nrec, 515);
        check(done && !trace_active, "R9 done when full", {done, trace_active}, 2);

        @(negedge clk) smp_valid = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule